// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Override

This block is an 8-bit general-purpose I/O port that sits on the CPU register bus. Software programs a direction register and an output data latch. A direction bit of 1 puts its pin into input mode, with the driver released to high impedance. A direction bit of 0 puts the latch bit on the pin. A third register address returns the levels present on the pins. The inputs coming back from the pads pass through a two-flop synchronizer before they reach the read path.

Any pin can be handed to an on-chip peripheral through a per-pin select. While the select is active, the peripheral's data bit drives the pad and the peripheral's output enable controls the driver. This override never changes the stored direction register, so software can read-modify-write that register safely. Latch reads and pin reads use separate paths, so a read-modify-write of the latch does not pick up pin levels. The peripherals always receive the synchronized pin levels, whatever direction each pin has.

The register interface is a plain address, write strobe and write data, and it has no back-pressure. A write completes on the clock edge where the strobe is high. Read data is a combinational function of the current address.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset the direction register reads 0xFF, the output latch reads 0x00, and no pad driver is enabled while no peripheral select is active.
- R2: A write to address 0 or address 1 loads the output latch on that clock edge. A read of address 1 returns the latch value.
- R3: A write to address 2 loads the direction register. A read of address 2 returns the value software last wrote there.
- R4: For a pin whose peripheral select is 0, the pad enable is the inverse of its direction bit (1 = driving) and the pad output is its latch bit.
- R5: For a pin whose peripheral select is 1, the pad output is its peripheral data bit and the pad enable is its peripheral output-enable bit, whatever the direction bit holds.
- R6: Peripheral selects and output enables never alter the stored direction register or the latch.
- R7: A read of address 0 returns the pad input levels delayed by exactly two clock edges. It never returns the latch.
- R8: The peripheral data-in bus carries the same two-edge-delayed pad levels for every pin, in either direction.
- R9: A read of address 3 returns 0x00, and a write to address 3 changes no register.
- R10: With the write strobe low, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 pins, 1 latch, 2 direction, 3 unused |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| periph_sel | input | 8 | Per-pin peripheral takeover |
| periph_oe | input | 8 | Per-pin peripheral driver enable, 1 = drive |
| periph_dout | input | 8 | Per-pin peripheral output data |
| periph_din | output | 8 | Synchronized pin levels for the peripherals |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Data toward the pads |
| pad_oe | output | 8 | Pad driver enable, 1 = drive |

## Verification
The output mux is tried against a table of patterns: all pins input, all pins output, a mixed direction split, and peripheral selects that cover only the low nibble, only the high nibble, or a scattered mask. Each pattern sets direction and peripheral enable against each other, so a swapped or ignored select shows up on individual bits. After every pattern the direction and latch are read back, which separates a true override from one that leaks into the stored registers. Directed tests then step a pad value through the synchronizer one edge at a time to pin the latency at two. They also read the pin levels while the latch holds a different value, and they drive writes to the unused address and writes with the strobe low.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_PINS  = 2'd0,
    SEL_LATCH = 2'd1,
    SEL_DIR   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  reg_sel_e     sel,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] dir_q
);
  logic lat_we, dir_we;

  always_comb begin
    lat_we = 1'b0;
    dir_we = 1'b0;
    if (wr) begin
      unique case (sel)
        SEL_PINS, SEL_LATCH: lat_we = 1'b1;
        SEL_DIR:             dir_we = 1'b1;
        default:             ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
    end else begin
      if (lat_we) lat_q <= wdata;
      if (dir_we) dir_q <= wdata;
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux (
  input  logic lat_bit,
  input  logic dir_bit,
  input  logic psel,
  input  logic poe,
  input  logic pdout,
  output logic pout,
  output logic poe_out
);
  always_comb begin
    if (psel) begin
      pout    = pdout;
      poe_out = poe;
    end else begin
      pout    = lat_bit;
      poe_out = ~dir_bit;
    end
  end
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_addr,
  input  logic         reg_wr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [W-1:0] periph_sel,
  input  logic [W-1:0] periph_oe,
  input  logic [W-1:0] periph_dout,
  output logic [W-1:0] periph_din,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  reg_sel_e     sel;
  logic [W-1:0] lat_q, dir_q, pins_q;

  assign sel = reg_sel_e'(reg_addr);

  gpio_regs #(.W(W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .lat_q (lat_q),
    .dir_q (dir_q)
  );

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pins_q)
  );

  assign periph_din = pins_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      gpio_pin_mux u_mux (
        .lat_bit (lat_q[i]),
        .dir_bit (dir_q[i]),
        .psel    (periph_sel[i]),
        .poe     (periph_oe[i]),
        .pdout   (periph_dout[i]),
        .pout    (pad_out[i]),
        .poe_out (pad_oe[i])
      );
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_PINS:  reg_rdata = pins_q;
      SEL_LATCH: reg_rdata = lat_q;
      SEL_DIR:   reg_rdata = dir_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_ovr_chk.sv
module gpio_port_ovr_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   reg_addr,
  input logic         reg_wr,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] reg_rdata,
  input logic [W-1:0] periph_sel,
  input logic [W-1:0] periph_oe,
  input logic [W-1:0] periph_dout,
  input logic [W-1:0] periph_din,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe
);
  logic [1:0] edges;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          edges <= '0;
    else if (edges != 2'd3) edges <= edges + 2'd1;
  end

  // R2
  a_r2_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr <= 2'd1) |=> (reg_addr != 2'd1 || reg_rdata == $past(reg_wdata)));

  // R3
  a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=> (reg_addr != 2'd2 || reg_rdata == $past(reg_wdata)));

  // R5
  a_r5_periph_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_out ^ periph_dout) | (pad_oe ^ periph_oe)) & periph_sel) == '0);

  // R6 and R10: direction holds without a write to it
  a_r6_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2 && !reg_wr) |=> (reg_addr != 2'd2 || $stable(reg_rdata)));

  // R7
  a_r7_pin_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (edges >= 2'd2 && reg_addr == 2'd0) |-> reg_rdata == $past(pad_in, 2));

  // R8
  a_r8_periph_in: assert property (@(posedge clk) disable iff (!rst_n)
    (edges >= 2'd2) |-> periph_din == $past(pad_in, 2));

  // R9
  a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> reg_rdata == '0);
endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_addr    (reg_addr),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .periph_sel  (periph_sel),
  .periph_oe   (periph_oe),
  .periph_dout (periph_dout),
  .periph_din  (periph_din),
  .pad_in      (pad_in),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe)
);

// File: tb/sim_gpio_port_ovr.sv
`timescale 1ns/1ps
module sim_gpio_port_ovr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] periph_sel = '0, periph_oe = '0, periph_dout = '0;
  logic [7:0] periph_din;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port_ovr u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_sel(periph_sel),
    .periph_oe(periph_oe), .periph_dout(periph_dout), .periph_din(periph_din),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // {dir, lat, sel, oe, pdout, exp_oe, exp_out}
  localparam logic [55:0] VEC [6] = '{
    {8'hFF, 8'hA5, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hA5},
    {8'h00, 8'h3C, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h3C},
    {8'hCF, 8'h30, 8'h00, 8'h00, 8'h00, 8'h30, 8'h30},
    {8'hFF, 8'h00, 8'h0F, 8'h05, 8'hFF, 8'h05, 8'h0F},
    {8'h00, 8'hFF, 8'hF0, 8'h30, 8'h00, 8'h3F, 8'h0F},
    {8'hAA, 8'h55, 8'hC3, 8'h81, 8'h5A, 8'h95, 8'h56}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [7:0] r;
    tick(); tick();
    // R1 reset state
    rd(2'd2, r); chk("R1 dir after reset", r, 8'hFF);
    rd(2'd1, r); chk("R1 latch after reset", r, 8'h00);
    chk("R1 pad_oe after reset", pad_oe, 8'h00);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < 6; i++) begin
      logic [7:0] vd, vl, vs, vo, vp, eo, eq;
      {vd, vl, vs, vo, vp, eo, eq} = VEC[i];
      wr(2'd2, vd);
      wr((i % 2 == 0) ? 2'd0 : 2'd1, vl);   // R2 both latch addresses
      periph_sel = vs; periph_oe = vo; periph_dout = vp;
      #0.5;
      chk("R4/R5 pad_oe", pad_oe, eo);
      chk("R4/R5 pad_out", pad_out, eq);
      tick();
      rd(2'd2, r); chk("R3/R6 dir readback", r, vd);
      rd(2'd1, r); chk("R2/R6 latch readback", r, vl);
    end

    // R7 two-edge latency, pins read separate from latch
    periph_sel = '0;
    wr(2'd1, 8'h5A);
    wr(2'd2, 8'hFF);
    pad_in = 8'h00; tick(); tick(); tick();
    pad_in = 8'h96;
    tick();
    rd(2'd0, r); chk("R7 pins after one edge", r, 8'h00);
    chk("R8 periph_din after one edge", periph_din, 8'h00);
    tick();
    rd(2'd0, r); chk("R7 pins after two edges", r, 8'h96);
    chk("R8 periph_din inputs", periph_din, 8'h96);
    // R8 with all pins outputs
    wr(2'd2, 8'h00);
    pad_in = 8'h3E; tick(); tick();
    chk("R8 periph_din outputs", periph_din, 8'h3E);
    rd(2'd1, r); chk("R7 latch unaffected by pins", r, 8'h5A);

    // R9 unused address
    rd(2'd3, r); chk("R9 read addr3", r, 8'h00);
    wr(2'd3, 8'hC3);
    rd(2'd1, r); chk("R9 latch after addr3 write", r, 8'h5A);
    rd(2'd2, r); chk("R9 dir after addr3 write", r, 8'h00);
    chk("R9 pad_out after addr3 write", pad_out, 8'h5A);

    // R10 strobe low
    reg_wdata = 8'hE7;
    reg_addr = 2'd1; tick();
    reg_addr = 2'd2; tick();
    reg_addr = 2'd0; tick();
    rd(2'd1, r); chk("R10 latch with strobe low", r, 8'h5A);
    rd(2'd2, r); chk("R10 dir with strobe low", r, 8'h00);
    chk("R10 pad_oe with strobe low", pad_oe, 8'hFF);

    done = 1'b1;
    report();
  end
endmodule